// File: doc/BRIEF.md
# Line-Controlled UART Framing Engine

A single-channel asynchronous serial transmitter and receiver whose character format comes from one 8-bit line control byte. Software programs a 16-bit baud divisor, picks a character length of 5 to 8 bits, one or two stop bits and a parity scheme, and then writes bytes to send and collects received bytes. The divisor bytes share register addresses with the data path. A select bit in the control byte steers those addresses to the divisor when set and to transmit and receive data when clear.

Parity is picked by three control bits: enable, even and stick. With stick set, the parity bit is fixed at mark or space on both transmit and receive. A break bit holds the serial output low whatever the transmitter is doing. The transmitter keeps sequencing the character underneath, so the line goes back to idle high when break is released. The receiver oversamples the line with a 16x tick taken from the divisor. It confirms a start bit at its half-bit point, samples each later bit at its centre and reports each byte as a one-cycle pulse with parity and framing error flags.

Top module: `uart_line_engine`

## Requirements
- R1: After reset the control byte reads 0x00, both divisor bytes read 0x00, `ser_out` is 1 and `tx_busy` is 0.
- R2: Register map on `reg_addr`: 0 is data, 1 is divisor-high, 2 is line control, 3 reads 0. When control bit 7 is 1, address 0 reads and writes the divisor low byte and address 1 reads and writes the divisor high byte. When bit 7 is 0, a write to address 0 starts a transmission, a read of address 0 returns the last received byte, and address 1 reads 0 and ignores writes.
- R3: Control bits 1:0 select 5, 6, 7 or 8 data bits (values 0 to 3). A frame is one low start bit, then the data least-significant bit first. Received bytes carry zeros above the character length.
- R4: When control bit 3 is 0, no parity bit is sent or checked, whatever bits 4 and 5 hold, and `rx_parity_err` stays 0.
- R5: When bit 3 is 1 and bit 5 is 0, the parity bit makes the count of ones over data plus parity odd when bit 4 is 0, and even when bit 4 is 1.
- R6: When bits 3 and 5 are 1, the parity bit is 1 if bit 4 is 0 and 0 if bit 4 is 1. This holds for transmit and receive alike.
- R7: The receiver raises `rx_parity_err` together with the `rx_valid` pulse of a byte whose parity bit differs from the one the current format expects. `rx_valid` lasts one cycle.
- R8: Control bit 2 at 0 gives one stop bit of 16 ticks. At 1 it gives 32 ticks, or 24 ticks for 5-bit characters. A character keeps `tx_busy` high for 16 ticks per start, data and parity bit plus the stop ticks.
- R9: `rx_frame_err` is raised with the byte when the sampled first stop bit is 0.
- R10: While control bit 6 is 1, `ser_out` is 0 starting two cycles after the write. A character in progress still completes on time. After bit 6 is cleared with the transmitter idle, `ser_out` returns to 1.
- R11: One 16x tick occurs every divisor-value clocks. A divisor of 0 stops the tick, so a started character stays in progress.
- R12: A low pulse on `ser_in` shorter than half a bit time produces no received byte.
- R13: A write to the data address while `tx_busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a byte is received |
| rx_parity_err | output | 1 | Parity mismatch on the byte marked by `rx_valid` |
| rx_frame_err | output | 1 | Stop bit low on the byte marked by `rx_valid` |
| tx_busy | output | 1 | Transmitter is sending a character |
| ser_out | output | 1 | Serial transmit line |
| ser_in | input | 1 | Serial receive line |

## Verification
The hardest cases to reach are receiver-side errors: a wrong parity bit, a low stop bit, a start glitch. A correct transmitter looped back can never produce them. So the bench switches `ser_in` from loopback to a bit-banged line and builds malformed frames bit by bit at the divisor's bit time. The other hard case is break raised in mid-character. Here the bench disconnects the receiver and watches `ser_out` and the length of `tx_busy`, which shows that the hidden character still runs its full tick count.

// File: rtl/uart_lc_pkg.sv
package uart_lc_pkg;

    localparam int OVS     = 16;
    localparam int TCW     = $clog2(2 * OVS) + 1;
    localparam int BYTE_W  = 8;
    localparam int DIV_W   = 2 * BYTE_W;

    localparam logic [1:0] ADDR_DATA  = 2'd0;
    localparam logic [1:0] ADDR_DIVHI = 2'd1;
    localparam logic [1:0] ADDR_LCR   = 2'd2;

    typedef struct packed {
        logic       dl_sel;
        logic       brk;
        logic       par_stick;
        logic       par_even;
        logic       par_en;
        logic       stop2;
        logic [1:0] len;
    } line_cfg_t;

    typedef struct packed {
        logic       par_stick;
        logic       par_even;
        logic       par_en;
        logic [1:0] len;
    } frame_fmt_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP,
        PH_HOLD
    } frame_phase_e;

    function automatic logic [BYTE_W-1:0] char_mask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction

    function automatic logic [2:0] last_idx(input logic [1:0] len);
        return 3'd4 + {1'b0, len};
    endfunction

    function automatic logic parity_of(input logic [BYTE_W-1:0] d, input frame_fmt_t f);
        logic [BYTE_W-1:0] m;
        m = d & char_mask(f.len);
        if (f.par_stick)
            return ~f.par_even;
        return f.par_even ? ^m : ~^m;
    endfunction

    function automatic logic [TCW-1:0] stop_len(input logic stop2, input logic [1:0] len);
        if (!stop2)
            return TCW'(OVS);
        return (len == 2'd0) ? TCW'(OVS + OVS / 2) : TCW'(2 * OVS);
    endfunction

endpackage

// File: rtl/uart_lc_baud.sv
module uart_lc_baud
    import uart_lc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (divisor == '0) begin
                cnt <= '0;
            end else if (cnt == '0) begin
                cnt  <= divisor - 1'b1;
                tick <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_lc_sync.sv
module uart_lc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '1;
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_lc_tx.sv
module uart_lc_tx
    import uart_lc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic [BYTE_W-1:0] data,
    input  frame_fmt_t        fmt,
    input  logic              stop2,
    output logic              busy,
    output logic              line
);
    frame_phase_e      phase;
    logic [TCW-1:0]    tcnt;
    logic [2:0]        bcnt;
    logic [BYTE_W-1:0] sr;
    frame_fmt_t        fmt_q;
    logic              stop2_q;
    logic              par_q;
    logic [TCW-1:0]    bit_len;
    logic              bit_done;

    assign bit_len  = (phase == PH_STOP) ? stop_len(stop2_q, fmt_q.len) : TCW'(OVS);
    assign bit_done = (tcnt == bit_len - 1'b1);
    assign busy     = (phase != PH_IDLE);

    always_comb begin
        unique case (phase)
            PH_START: line = 1'b0;
            PH_DATA:  line = sr[0];
            PH_PAR:   line = par_q;
            default:  line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            tcnt    <= '0;
            bcnt    <= '0;
            sr      <= '0;
            fmt_q   <= '0;
            stop2_q <= 1'b0;
            par_q   <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        sr      <= data;
                        fmt_q   <= fmt;
                        stop2_q <= stop2;
                        par_q   <= parity_of(data, fmt);
                        tcnt    <= '0;
                        phase   <= PH_START;
                    end
                end
                default: begin
                    if (tick) begin
                        if (!bit_done) begin
                            tcnt <= tcnt + 1'b1;
                        end else begin
                            tcnt <= '0;
                            case (phase)
                                PH_START: begin
                                    phase <= PH_DATA;
                                    bcnt  <= '0;
                                end
                                PH_DATA: begin
                                    sr <= {1'b0, sr[BYTE_W-1:1]};
                                    if (bcnt == last_idx(fmt_q.len))
                                        phase <= fmt_q.par_en ? PH_PAR : PH_STOP;
                                    else
                                        bcnt <= bcnt + 1'b1;
                                end
                                PH_PAR:  phase <= PH_STOP;
                                default: phase <= PH_IDLE;
                            endcase
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_lc_rx.sv
module uart_lc_rx
    import uart_lc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rxd,
    input  frame_fmt_t        fmt,
    output logic              valid,
    output logic [BYTE_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    frame_phase_e      phase;
    logic [TCW-1:0]    tcnt;
    logic [2:0]        bcnt;
    logic [BYTE_W-1:0] sr;
    frame_fmt_t        fmt_q;
    logic              par_q;
    logic [BYTE_W-1:0] aligned;

    assign aligned = sr >> (2'd3 - fmt_q.len);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            tcnt  <= '0;
            bcnt  <= '0;
            sr    <= '0;
            fmt_q <= '0;
            par_q <= 1'b0;
            valid <= 1'b0;
            data  <= '0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (!rxd) begin
                        phase <= PH_START;
                        tcnt  <= '0;
                        fmt_q <= fmt;
                    end
                end
                PH_START: begin
                    if (tick) begin
                        if (tcnt == TCW'(OVS / 2 - 1)) begin
                            tcnt <= '0;
                            if (!rxd) begin
                                phase <= PH_DATA;
                                bcnt  <= '0;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                PH_HOLD: begin
                    if (rxd)
                        phase <= PH_IDLE;
                end
                default: begin
                    if (tick) begin
                        if (tcnt != TCW'(OVS - 1)) begin
                            tcnt <= tcnt + 1'b1;
                        end else begin
                            tcnt <= '0;
                            case (phase)
                                PH_DATA: begin
                                    sr <= {rxd, sr[BYTE_W-1:1]};
                                    if (bcnt == last_idx(fmt_q.len))
                                        phase <= fmt_q.par_en ? PH_PAR : PH_STOP;
                                    else
                                        bcnt <= bcnt + 1'b1;
                                end
                                PH_PAR: begin
                                    par_q <= rxd;
                                    phase <= PH_STOP;
                                end
                                PH_STOP: begin
                                    valid <= 1'b1;
                                    data  <= aligned;
                                    ferr  <= ~rxd;
                                    perr  <= fmt_q.par_en && (par_q != parity_of(aligned, fmt_q));
                                    phase <= rxd ? PH_IDLE : PH_HOLD;
                                end
                                default: phase <= PH_IDLE;
                            endcase
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_line_engine.sv
module uart_line_engine
    import uart_lc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_parity_err,
    output logic              rx_frame_err,
    output logic              tx_busy,
    output logic              ser_out,
    input  logic              ser_in
);
    line_cfg_t         lcr_q;
    logic [BYTE_W-1:0] div_lo;
    logic [BYTE_W-1:0] div_hi;
    logic [DIV_W-1:0]  divisor;
    frame_fmt_t        fmt;
    logic              tick;
    logic              tx_start;
    logic              tx_line;
    logic              rxd;

    assign divisor  = {div_hi, div_lo};
    assign fmt      = '{par_stick: lcr_q.par_stick, par_even: lcr_q.par_even,
                        par_en: lcr_q.par_en, len: lcr_q.len};
    assign tx_start = reg_wr && (reg_addr == ADDR_DATA) && !lcr_q.dl_sel && !tx_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            lcr_q  <= '0;
            div_lo <= '0;
            div_hi <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_DATA:  if (lcr_q.dl_sel) div_lo <= reg_wdata;
                ADDR_DIVHI: if (lcr_q.dl_sel) div_hi <= reg_wdata;
                ADDR_LCR:   lcr_q <= line_cfg_t'(reg_wdata);
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_DATA:  reg_rdata = lcr_q.dl_sel ? div_lo : rx_data;
            ADDR_DIVHI: reg_rdata = lcr_q.dl_sel ? div_hi : '0;
            ADDR_LCR:   reg_rdata = lcr_q;
            default:    reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            ser_out <= 1'b1;
        else
            ser_out <= lcr_q.brk ? 1'b0 : tx_line;
    end

    uart_lc_baud u_baud (
        .clk     (clk),
        .rst     (rst),
        .divisor (divisor),
        .tick    (tick)
    );

    uart_lc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ser_in),
        .q   (rxd)
    );

    uart_lc_tx u_tx (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .start (tx_start),
        .data  (reg_wdata),
        .fmt   (fmt),
        .stop2 (lcr_q.stop2),
        .busy  (tx_busy),
        .line  (tx_line)
    );

    uart_lc_rx u_rx (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .rxd   (rxd),
        .fmt   (fmt),
        .valid (rx_valid),
        .data  (rx_data),
        .perr  (rx_parity_err),
        .ferr  (rx_frame_err)
    );
endmodule

// File: rtl/uart_line_engine_chk.sv
module uart_line_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic        wdata_brk,
    input logic        ser_out,
    input logic        tx_busy,
    input logic        rx_valid,
    input logic        rx_parity_err,
    input logic        par_en_q,
    input logic        brk_q,
    input logic [15:0] div_q
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ser_out && !tx_busy));

    assert_start_low_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |=> !ser_out);

    assert_no_parity_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !par_en_q) |-> !rx_parity_err);

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_break_drive_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_wr && reg_addr == 2'd2 && wdata_brk)) |=> !ser_out);

    assert_idle_high_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !tx_busy && !$past(tx_busy) && !brk_q && !$past(brk_q)) |-> ser_out);

    assert_tick_halt_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && div_q == 16'd0 && $past(div_q) == 16'd0 && tx_busy) |=> tx_busy);
endmodule

bind uart_line_engine uart_line_engine_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .wdata_brk     (reg_wdata[6]),
    .ser_out       (ser_out),
    .tx_busy       (tx_busy),
    .rx_valid      (rx_valid),
    .rx_parity_err (rx_parity_err),
    .par_en_q      (lcr_q.par_en),
    .brk_q         (lcr_q.brk),
    .div_q         (divisor)
);

// File: tb/uart_line_engine_tb.sv
module uart_line_engine_tb;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [7:0] rx_data;
    logic       rx_valid, rx_parity_err, rx_frame_err, tx_busy, ser_out, ser_in;
    logic       bb_mode, bb_line;

    always #10 clk = ~clk;
    assign ser_in = bb_mode ? bb_line : ser_out;

    uart_line_engine u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
        .tx_busy(tx_busy), .ser_out(ser_out), .ser_in(ser_in)
    );

    typedef struct { logic [7:0] d; logic pe; logic fe; string tag; } exp_t;
    exp_t sb_q[$];
    exp_t mon_e;
    int checks = 0, fails = 0, rx_count = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            rx_count++;
            if (sb_q.size() == 0) begin
                check(1'b0, "R12 unexpected byte", {22'd0, rx_frame_err, rx_parity_err, rx_data}, 32'hFFFF_FFFF);
            end else begin
                mon_e = sb_q.pop_front();
                check(rx_data == mon_e.d && rx_parity_err == mon_e.pe && rx_frame_err == mon_e.fe,
                      mon_e.tag, {22'd0, rx_frame_err, rx_parity_err, rx_data},
                      {22'd0, mon_e.fe, mon_e.pe, mon_e.d});
            end
        end
    end

    function automatic logic exp_par(input logic [7:0] d, input int n, input logic even, input logic stick);
        int ones = 0;
        for (int i = 0; i < n; i++) ones += d[i];
        if (stick) return !even;
        return even ? (ones % 2 == 1) : (ones % 2 == 0);
    endfunction

    function automatic logic [7:0] mask_of(input int n);
        return 8'((9'd1 << n) - 1);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == e, tag, {24'd0, reg_rdata}, {24'd0, e});
    endtask

    task automatic wait_idle();
        while (tx_busy) @(negedge clk);
    endtask

    task automatic wait_drain(input string tag);
        for (int i = 0; i < 4000 && sb_q.size() != 0; i++) @(negedge clk);
        if (sb_q.size() != 0) begin
            check(1'b0, {tag, " missing byte"}, sb_q.size(), 0);
            sb_q.delete();
        end
        wait_idle();
        repeat (40) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic pe, input logic fe, input string tag);
        exp_t e;
        e.d = d; e.pe = pe; e.fe = fe; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // loopback transmit with frame capture on ser_out
    task automatic cap_frame(input logic [7:0] lcr, input logic [7:0] d, input string tag);
        int n = 5 + int'(lcr[1:0]);
        int p = int'(lcr[3]);
        int nb = 1 + n + p + 1;
        logic [11:0] got = '0, want = '0;
        wait_idle();
        wr(2'd2, lcr);
        push(d & mask_of(n), 1'b0, 1'b0, tag);
        wr(2'd0, d);
        while (ser_out) @(negedge clk);
        repeat (BITCLK / 2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            got[i] = ser_out;
            if (i != nb - 1) repeat (BITCLK) @(negedge clk);
        end
        want[0] = 1'b0;
        for (int i = 0; i < n; i++) want[1 + i] = d[i];
        if (p == 1) want[1 + n] = exp_par(d, n, lcr[4], lcr[5]);
        want[nb - 1] = 1'b1;
        check(got == want, tag, {20'd0, got}, {20'd0, want});
        wait_drain(tag);
    endtask

    task automatic bb_frame(input logic [7:0] d, input int n, input bit has_par, input logic pv, input logic sv);
        @(negedge clk);
        bb_line = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            bb_line = d[i];
            repeat (BITCLK) @(negedge clk);
        end
        if (has_par) begin
            bb_line = pv;
            repeat (BITCLK) @(negedge clk);
        end
        bb_line = sv;
        repeat (BITCLK) @(negedge clk);
        bb_line = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
    endtask

    task automatic measure(input logic [7:0] lcr, input logic [7:0] d, input int ticks, input string tag);
        int cnt = 0;
        int n = 5 + int'(lcr[1:0]);
        wait_idle();
        wr(2'd2, lcr);
        push(d & mask_of(n), 1'b0, 1'b0, tag);
        wr(2'd0, d);
        while (tx_busy) begin
            @(negedge clk);
            cnt++;
        end
        check(cnt >= ticks * 4 - 6 && cnt <= ticks * 4 + 2, tag, cnt, ticks * 4);
        wait_drain(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired R1 act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int c0;
        int cnt;
        bit bad;
        rst = 1'b1; reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = 8'd0;
        bb_mode = 1'b0; bb_line = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(ser_out == 1'b1, "R1 ser_out idle", ser_out, 1);
        check(tx_busy == 1'b0, "R1 tx_busy", tx_busy, 0);
        rd(2'd2, 8'h00, "R1 lcr reset");
        wr(2'd2, 8'h80);
        rd(2'd0, 8'h00, "R1 div lo reset");
        rd(2'd1, 8'h00, "R1 div hi reset");

        // R2 divisor routing
        wr(2'd1, 8'h12);
        rd(2'd1, 8'h12, "R2 div hi write");
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h04);
        rd(2'd0, 8'h04, "R2 div lo write");
        check(tx_busy == 1'b0, "R2 divisor write no tx", tx_busy, 0);
        wr(2'd2, 8'h03);
        wr(2'd1, 8'h77);
        rd(2'd1, 8'h00, "R2 addr1 data side");
        rd(2'd2, 8'h03, "R2 lcr readback");
        rd(2'd3, 8'h00, "R2 addr3");

        // R3 lengths and bit order, R4 no parity, R5/R6 parity bit values
        cap_frame(8'h03, 8'hA5, "R3 8-bit frame");
        cap_frame(8'h01, 8'hE6, "R3 6-bit frame");
        cap_frame(8'h00, 8'hFF, "R3 5-bit frame");
        cap_frame(8'h30, 8'h15, "R4 5-bit no parity stick/even ignored");
        cap_frame(8'h1A, 8'h45, "R5 7-bit even");
        cap_frame(8'h0B, 8'h33, "R5 8-bit odd");
        cap_frame(8'h0B, 8'h31, "R5 8-bit odd odd-count");
        cap_frame(8'h2B, 8'h00, "R6 mark");
        cap_frame(8'h3B, 8'hFF, "R6 space");
        rd(2'd0, 8'hFF, "R2 read last rx byte");

        // R8 stop lengths
        measure(8'h03, 8'h5A, 160, "R8 8N1 length");
        measure(8'h07, 8'h5A, 176, "R8 8N2 length");
        measure(8'h00, 8'h0A, 112, "R8 5N1 length");
        measure(8'h04, 8'h0A, 120, "R8 5-bit 1.5 stop length");
        measure(8'h0F, 8'hC3, 192, "R8 8O2 length");

        // R7 parity check on receive, R4 with bits 4/5 set
        bb_mode = 1'b1; bb_line = 1'b1;
        wr(2'd2, 8'h1B);
        push(8'h37, 1'b0, 1'b0, "R7 even good parity");
        bb_frame(8'h37, 8, 1'b1, 1'b1, 1'b1);
        push(8'h37, 1'b1, 1'b0, "R7 even bad parity");
        bb_frame(8'h37, 8, 1'b1, 1'b0, 1'b1);
        wr(2'd2, 8'h0B);
        push(8'h01, 1'b1, 1'b0, "R7 odd bad parity");
        bb_frame(8'h01, 8, 1'b1, 1'b1, 1'b1);
        wr(2'd2, 8'h2B);
        push(8'hF0, 1'b1, 1'b0, "R6 rx mark expects 1");
        bb_frame(8'hF0, 8, 1'b1, 1'b0, 1'b1);
        wr(2'd2, 8'h3A);
        push(8'h7F, 1'b0, 1'b0, "R6 rx space accepts 0");
        bb_frame(8'h7F, 7, 1'b1, 1'b0, 1'b1);
        wr(2'd2, 8'h33);
        push(8'h96, 1'b0, 1'b0, "R4 rx no parity");
        bb_frame(8'h96, 8, 1'b0, 1'b0, 1'b1);

        // R9 framing error
        wr(2'd2, 8'h03);
        push(8'h81, 1'b0, 1'b1, "R9 stop low");
        bb_frame(8'h81, 8, 1'b0, 1'b0, 1'b0);
        push(8'h42, 1'b0, 1'b0, "R9 recovery");
        bb_frame(8'h42, 8, 1'b0, 1'b0, 1'b1);
        wait_drain("R9");

        // R12 short glitch
        c0 = rx_count;
        bb_line = 1'b0;
        repeat (16) @(negedge clk);
        bb_line = 1'b1;
        repeat (2000) @(negedge clk);
        check(rx_count == c0, "R12 glitch rejected", rx_count, c0);

        // R10 break during a character
        wr(2'd0, 8'hFF);
        wr(2'd2, 8'h43);
        @(negedge clk);
        bad = 1'b0;
        cnt = 0;
        while (tx_busy) begin
            if (ser_out) bad = 1'b1;
            @(negedge clk);
            cnt++;
        end
        check(!bad, "R10 line low during break", bad, 0);
        check(cnt >= 600 && cnt <= 640, "R10 character completes under break", cnt, 634);
        repeat (200) @(negedge clk);
        check(ser_out == 1'b0, "R10 break held while idle", ser_out, 0);
        wr(2'd2, 8'h03);
        repeat (3) @(negedge clk);
        check(ser_out == 1'b1, "R10 idle after break release", ser_out, 1);

        // R11 zero divisor halts
        wr(2'd2, 8'h80);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h5A);
        repeat (1000) @(negedge clk);
        check(tx_busy == 1'b1 && ser_out == 1'b0, "R11 stalled at divisor 0", {tx_busy, ser_out}, 2'b10);
        wr(2'd2, 8'h80);
        wr(2'd0, 8'h04);
        wr(2'd2, 8'h03);
        for (int i = 0; i < 2000 && tx_busy; i++) @(negedge clk);
        check(tx_busy == 1'b0, "R11 resumes with divisor", tx_busy, 0);
        repeat (40) @(negedge clk);

        // R13 write while busy ignored
        bb_mode = 1'b0;
        repeat (10) @(negedge clk);
        c0 = rx_count;
        push(8'h55, 1'b0, 1'b0, "R13 first byte kept");
        wr(2'd0, 8'h55);
        wr(2'd0, 8'h0F);
        wait_drain("R13");
        repeat (1500) @(negedge clk);
        check(rx_count == c0 + 1, "R13 second write dropped", rx_count, c0 + 1);
        rd(2'd0, 8'h55, "R13 last byte");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule